// File: doc/BRIEF.md
# Speculative Load Poison Tracker

This block holds one poison bit for each general register and uses those bits to defer load faults. A speculative load that faults does not trap. It marks its destination register as poisoned. A later check instruction on that register sends control to a repair sequence. The repair sequence reissues the load without speculation. If the reissued load completes, control goes back to the instruction after the check. If the reissued load faults, the normal exception is raised.

The block sits at the retire stage of a simple in-order pipeline. Each cycle it accepts at most one register-write event and at most one check event. A write event carries a kind, a destination register and a fault flag. A check event carries a register, a repair target and the program counter of the check.

The core is a two-state controller:
- **ST_RUN** is normal operation. The transition *check hit* (a check on a poisoned register) issues a redirect and moves to ST_AWAIT_REPAIR.
- **ST_AWAIT_REPAIR** waits for the reissued load. The transition *repair done* (a normal load to the checked register) moves back to ST_RUN. It issues a resume request when the load does not fault.

All outputs are registered single-cycle pulses. They appear in the cycle after the event that causes them.

Top module: `spec_poison_tracker`

## Requirements
- R1: After reset, every output pulse is low and every poison bit is clear, so a check on any register produces no redirect.
- R2: A speculative load (`wr_kind` 2'b10) with `wr_fault` set raises no exception and sets the poison bit of its destination.
- R3: In ST_RUN, a check on a poisoned register raises `redir_valid` in the next cycle with `redir_target` equal to the check's target, and enters ST_AWAIT_REPAIR.
- R4: A check on a register whose poison bit is clear produces no redirect.
- R5: A normal load (`wr_kind` 2'b01) with `wr_fault` set raises `exc_valid` in the next cycle with `exc_reg` equal to its destination, in either state. Its poison bit stays unchanged.
- R6: In ST_AWAIT_REPAIR, a normal load to the checked register returns to ST_RUN. If it does not fault, it raises `resume_valid` with `resume_pc` equal to the check's pc plus INSN_BYTES. If it faults, no resume is issued.
- R7: A speculative load without a fault clears the poison bit of its destination.
- R8: A completed normal load, or an ALU write (`wr_kind` 2'b00, where the fault flag is ignored), clears the poison bit of its destination. Kind 2'b11 has no effect.
- R9: Register 0 is never poisoned, so a check on register 0 never redirects.
- R10: When a check and a write name the same register in the same cycle, the check uses the poison value from before the write.
- R11: In ST_AWAIT_REPAIR, check events are ignored. A redirect and a resume are never raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A register-write event retires this cycle |
| wr_kind | input | 2 | 00 ALU, 01 normal load, 10 speculative load, 11 none |
| wr_reg | input | REG_W | Destination register |
| wr_fault | input | 1 | The load faulted |
| chk_valid | input | 1 | A check event retires this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_target | input | PC_W | Repair target |
| chk_pc | input | PC_W | Address of the check instruction |
| redir_valid | output | 1 | Branch to the repair target |
| redir_target | output | PC_W | Repair target address |
| resume_valid | output | 1 | Return after a successful repair |
| resume_pc | output | PC_W | Address of the instruction after the check |
| exc_valid | output | 1 | A normal load faulted |
| exc_reg | output | REG_W | Destination register of the faulting load |

## Verification
The assertions check these properties on every cycle:
- a faulting speculative load never produces an exception, and a faulting normal load always does, with the right register;
- every redirect follows a check and carries that check's target;
- register 0 never redirects;
- redirect and resume never coincide.

Other behaviour depends on a chain of events, and only the bench scenarios can show it. This covers:
- poison persisting across cycles;
- clearing by the different write kinds;
- same-cycle check-before-write ordering;
- the return address after a repair;
- a repair load that faults a second time.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;
    typedef enum logic [1:0] {
        WK_ALU   = 2'b00,
        WK_LOAD  = 2'b01,
        WK_SPEC  = 2'b10,
        WK_NONE  = 2'b11
    } wr_kind_e;

    typedef enum logic {
        ST_RUN          = 1'b0,
        ST_AWAIT_REPAIR = 1'b1
    } rep_state_e;
endpackage

// File: rtl/ptrk_poison_file.sv
module ptrk_poison_file #(
    parameter int NREGS = 64,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [REG_W-1:0] rd_idx,
    output logic             rd_bit
);
    logic [NREGS-1:0] bits_q;

    for (genvar i = 0; i < NREGS; i++) begin : g_bit
        if (i == 0) begin : g_zero
            // register 0 can never hold poison
            assign bits_q[i] = 1'b0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    bits_q[i] <= 1'b0;
                end else if (wr_idx == REG_W'(i)) begin
                    if (set_en)      bits_q[i] <= 1'b1;
                    else if (clr_en) bits_q[i] <= 1'b0;
                end
            end
        end
    end

    // read port sees the value from before this cycle's update
    assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/ptrk_repair_fsm.sv
module ptrk_repair_fsm
    import ptrk_pkg::*;
#(
    parameter int NREGS      = 64,
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_valid,
    input  logic             chk_poisoned,
    input  logic [REG_W-1:0] chk_reg,
    input  logic [PC_W-1:0]  chk_target,
    input  logic [PC_W-1:0]  chk_pc,
    input  logic             load_done,
    input  logic             load_fault,
    input  logic [REG_W-1:0] load_reg,
    output logic             redir_valid,
    output logic [PC_W-1:0]  redir_target,
    output logic             resume_valid,
    output logic [PC_W-1:0]  resume_pc
);
    rep_state_e       state_q, state_d;
    logic [REG_W-1:0] rep_reg_q;
    logic [PC_W-1:0]  ret_pc_q;
    logic             hit, repaired;

    assign hit      = chk_valid && chk_poisoned;
    assign repaired = load_done && (load_reg == rep_reg_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:          if (hit)      state_d = ST_AWAIT_REPAIR;
            ST_AWAIT_REPAIR: if (repaired) state_d = ST_RUN;
            default:                       state_d = ST_RUN;
        endcase
    end

    // outputs and repair context
    always_ff @(posedge clk) begin
        if (rst) begin
            redir_valid  <= 1'b0;
            redir_target <= '0;
            resume_valid <= 1'b0;
            resume_pc    <= '0;
            rep_reg_q    <= '0;
            ret_pc_q     <= '0;
        end else begin
            redir_valid  <= 1'b0;
            resume_valid <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (hit) begin
                        redir_valid  <= 1'b1;
                        redir_target <= chk_target;
                        rep_reg_q    <= chk_reg;
                        ret_pc_q     <= chk_pc + PC_W'(INSN_BYTES);
                    end
                end
                ST_AWAIT_REPAIR: begin
                    if (repaired && !load_fault) begin
                        resume_valid <= 1'b1;
                        resume_pc    <= ret_pc_q;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spec_poison_tracker.sv
module spec_poison_tracker
    import ptrk_pkg::*;
#(
    parameter int NREGS      = 64,
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [1:0]       wr_kind,
    input  logic [REG_W-1:0] wr_reg,
    input  logic             wr_fault,
    input  logic             chk_valid,
    input  logic [REG_W-1:0] chk_reg,
    input  logic [PC_W-1:0]  chk_target,
    input  logic [PC_W-1:0]  chk_pc,
    output logic             redir_valid,
    output logic [PC_W-1:0]  redir_target,
    output logic             resume_valid,
    output logic [PC_W-1:0]  resume_pc,
    output logic             exc_valid,
    output logic [REG_W-1:0] exc_reg
);
    wr_kind_e kind;
    logic     set_en, clr_en, poisoned, load_ok_or_bad;

    assign kind = wr_kind_e'(wr_kind);

    always_comb begin
        set_en = 1'b0;
        clr_en = 1'b0;
        if (wr_valid) begin
            unique case (kind)
                WK_SPEC: begin
                    set_en = wr_fault;
                    clr_en = !wr_fault;
                end
                WK_LOAD: clr_en = !wr_fault;
                WK_ALU:  clr_en = 1'b1;
                WK_NONE: ;
                default: ;
            endcase
        end
    end

    assign load_ok_or_bad = wr_valid && (kind == WK_LOAD);

    ptrk_poison_file #(.NREGS(NREGS)) u_file (
        .clk    (clk),
        .rst    (rst),
        .set_en (set_en),
        .clr_en (clr_en),
        .wr_idx (wr_reg),
        .rd_idx (chk_reg),
        .rd_bit (poisoned)
    );

    ptrk_repair_fsm #(
        .NREGS(NREGS), .PC_W(PC_W), .INSN_BYTES(INSN_BYTES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .chk_valid    (chk_valid),
        .chk_poisoned (poisoned),
        .chk_reg      (chk_reg),
        .chk_target   (chk_target),
        .chk_pc       (chk_pc),
        .load_done    (load_ok_or_bad),
        .load_fault   (wr_fault),
        .load_reg     (wr_reg),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .resume_valid (resume_valid),
        .resume_pc    (resume_pc)
    );

    // fault on a non-speculative load traps at once
    always_ff @(posedge clk) begin
        if (rst) begin
            exc_valid <= 1'b0;
            exc_reg   <= '0;
        end else begin
            exc_valid <= load_ok_or_bad && wr_fault;
            if (load_ok_or_bad && wr_fault) exc_reg <= wr_reg;
        end
    end
endmodule

// File: rtl/ptrk_checker.sv
module ptrk_checker #(
    parameter int NREGS = 64,
    parameter int PC_W  = 32,
    localparam int REG_W = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic [1:0]       wr_kind,
    input logic [REG_W-1:0] wr_reg,
    input logic             wr_fault,
    input logic             chk_valid,
    input logic [REG_W-1:0] chk_reg,
    input logic [PC_W-1:0]  chk_target,
    input logic             redir_valid,
    input logic [PC_W-1:0]  redir_target,
    input logic             resume_valid,
    input logic             exc_valid,
    input logic [REG_W-1:0] exc_reg
);
    AST_SPEC_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_kind == 2'b10 && wr_fault) |=> !exc_valid); // R2

    AST_LOAD_TRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_kind == 2'b01 && wr_fault) |=> (exc_valid && exc_reg == $past(wr_reg))); // R5

    AST_REDIR_FROM_CHECK: assert property (@(posedge clk) disable iff (rst)
        (chk_valid) |=> (!redir_valid || redir_target == $past(chk_target))); // R3

    AST_REDIR_NEEDS_CHECK: assert property (@(posedge clk) disable iff (rst)
        (!chk_valid) |=> !redir_valid); // R3

    AST_R0_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_reg == '0) |=> !redir_valid); // R9

    AST_REDIR_RESUME_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({redir_valid, resume_valid})); // R11
endmodule

bind spec_poison_tracker ptrk_checker #(.NREGS(NREGS), .PC_W(PC_W)) u_ptrk_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_kind      (wr_kind),
    .wr_reg       (wr_reg),
    .wr_fault     (wr_fault),
    .chk_valid    (chk_valid),
    .chk_reg      (chk_reg),
    .chk_target   (chk_target),
    .redir_valid  (redir_valid),
    .redir_target (redir_target),
    .resume_valid (resume_valid),
    .exc_valid    (exc_valid),
    .exc_reg      (exc_reg)
);

// File: tb/spec_poison_tracker_bench.sv
module spec_poison_tracker_bench;
    localparam int NREGS = 64;
    localparam int PC_W  = 32;
    localparam int INSN  = 4;
    localparam int RW    = $clog2(NREGS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0, wr_fault = 1'b0, chk_valid = 1'b0;
    logic [1:0] wr_kind = 2'b11;
    logic [RW-1:0] wr_reg = '0, chk_reg = '0;
    logic [PC_W-1:0] chk_target = '0, chk_pc = '0;
    logic redir_valid, resume_valid, exc_valid;
    logic [PC_W-1:0] redir_target, resume_pc;
    logic [RW-1:0] exc_reg;

    always #2 clk = ~clk;

    spec_poison_tracker #(.NREGS(NREGS), .PC_W(PC_W), .INSN_BYTES(INSN)) u_spec_poison_tracker (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_reg(wr_reg), .wr_fault(wr_fault),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_target(chk_target), .chk_pc(chk_pc),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .resume_valid(resume_valid), .resume_pc(resume_pc),
        .exc_valid(exc_valid), .exc_reg(exc_reg)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model
    bit            m_poison [NREGS];
    bit            m_await;
    logic [RW-1:0] m_rep;
    logic [PC_W-1:0] m_ret;

    function automatic bit exp_redirect(logic cv, logic [RW-1:0] cr);
        return !m_await && cv && m_poison[cr];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic wv, input logic [1:0] wk, input logic [RW-1:0] wr,
                        input logic wf, input logic cv, input logic [RW-1:0] cr,
                        input logic [PC_W-1:0] ct, input logic [PC_W-1:0] cp,
                        input string tag);
        bit e_red, e_res, e_exc;
        logic [PC_W-1:0] e_rpc;
        wr_valid = wv; wr_kind = wk; wr_reg = wr; wr_fault = wf;
        chk_valid = cv; chk_reg = cr; chk_target = ct; chk_pc = cp;
        // expected outputs from the pre-cycle model state
        e_red = exp_redirect(cv, cr);
        e_exc = wv && wk == 2'b01 && wf;
        e_res = m_await && wv && wk == 2'b01 && wr == m_rep && !wf;
        e_rpc = m_ret;
        // state update
        if (e_red) begin
            m_await = 1'b1; m_rep = cr; m_ret = cp + INSN;
        end else if (m_await && wv && wk == 2'b01 && wr == m_rep) begin
            m_await = 1'b0;
        end
        if (wv && wr != '0) begin
            case (wk)
                2'b10: m_poison[wr] = wf;
                2'b01: if (!wf) m_poison[wr] = 1'b0;
                2'b00: m_poison[wr] = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(redir_valid == e_red, tag, "redir_valid", PC_W'(redir_valid), PC_W'(e_red));
        if (e_red) check(redir_target == ct, tag, "redir_target", redir_target, ct);
        check(resume_valid == e_res, tag, "resume_valid", PC_W'(resume_valid), PC_W'(e_res));
        if (e_res) check(resume_pc == e_rpc, tag, "resume_pc", resume_pc, e_rpc);
        check(exc_valid == e_exc, tag, "exc_valid", PC_W'(exc_valid), PC_W'(e_exc));
        if (e_exc) check(exc_reg == wr, tag, "exc_reg", PC_W'(exc_reg), PC_W'(wr));
    endtask

    task automatic idle(input string tag);
        step(0, 2'b11, '0, 0, 0, '0, '0, '0, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < NREGS; i++) m_poison[i] = 1'b0;
        m_await = 1'b0; m_rep = '0; m_ret = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: outputs quiet after reset
        check(!redir_valid && !resume_valid && !exc_valid, "R1", "pulses",
              PC_W'({redir_valid, resume_valid, exc_valid}), '0);
        for (int r = 0; r < 8; r++) step(0, 2'b11, '0, 0, 1, RW'(r), 32'h200, 32'h10, "R1");

        step(1, 2'b10, 6'd5, 1, 0, '0, '0, '0, "R2");               // spec fault r5
        step(0, 2'b11, '0, 0, 1, 6'd5, 32'h100, 32'h40, "R3");      // check hits
        step(0, 2'b11, '0, 0, 1, 6'd5, 32'h300, 32'h80, "R11");     // ignored while awaiting
        step(1, 2'b01, 6'd5, 0, 0, '0, '0, '0, "R6");               // repair load ok -> resume 0x44
        step(0, 2'b11, '0, 0, 1, 6'd5, 32'h100, 32'h50, "R4");      // now clear

        step(1, 2'b10, 6'd0, 1, 0, '0, '0, '0, "R9");
        step(0, 2'b11, '0, 0, 1, 6'd0, 32'h120, 32'h60, "R9");

        step(1, 2'b10, 6'd7, 1, 0, '0, '0, '0, "R7");
        step(1, 2'b10, 6'd7, 0, 0, '0, '0, '0, "R7");
        step(0, 2'b11, '0, 0, 1, 6'd7, 32'h140, 32'h64, "R7");

        step(1, 2'b10, 6'd9, 1, 0, '0, '0, '0, "R8");
        step(1, 2'b00, 6'd9, 1, 0, '0, '0, '0, "R8");               // ALU ignores fault, clears
        step(0, 2'b11, '0, 0, 1, 6'd9, 32'h160, 32'h68, "R8");
        step(1, 2'b10, 6'd10, 1, 0, '0, '0, '0, "R8");
        step(1, 2'b11, 6'd10, 0, 0, '0, '0, '0, "R8");              // kind 11 no effect
        step(0, 2'b11, '0, 0, 1, 6'd10, 32'h170, 32'h6c, "R8");     // still poisoned -> redirect
        step(1, 2'b01, 6'd10, 0, 0, '0, '0, '0, "R6");

        step(1, 2'b10, 6'd3, 1, 0, '0, '0, '0, "R10");
        step(1, 2'b00, 6'd3, 0, 1, 6'd3, 32'h180, 32'h70, "R10");   // check sees old poison
        step(1, 2'b10, 6'd3, 1, 0, '0, '0, '0, "R10");
        step(1, 2'b01, 6'd3, 1, 0, '0, '0, '0, "R5");               // ends wait, no resume
        step(0, 2'b11, '0, 0, 1, 6'd3, 32'h1a0, 32'h74, "R5");      // still poisoned
        step(1, 2'b01, 6'd3, 0, 0, '0, '0, '0, "R6");
        step(1, 2'b10, 6'd4, 1, 1, 6'd4, 32'h1c0, 32'h78, "R10");   // old value clear
        step(1, 2'b01, 6'd12, 1, 0, '0, '0, '0, "R5");
        idle("R1");

        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 10) < 7, 2'($urandom % 4), RW'($urandom % 8),
                 ($urandom % 10) < 3, ($urandom % 10) < 4, RW'($urandom % 8),
                 {$urandom} & 32'hffff_fffc, {$urandom} & 32'hffff_fffc,
                 "RND R2 R3 R5 R6");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule